// File: doc/BRIEF.md
# Binary-Tree Bus Discovery Master

This block runs the host side of a bit-wise discovery protocol on a shared single-wire bus. Every device on that bus holds a unique identity of `ID_W` bits. The block finds every identity by running repeated search passes. Each pass follows one stored route through the identity tree and ends with exactly one device. Each pass also stores the unexplored sibling branches it meets as new routes in a small FIFO.

Below the block is a slot-level bus engine. The block asks the engine for one operation at a time over a request/acknowledge handshake: a bus reset, the search command, a response-slot pair, or a decision bit. For a response-slot pair, the engine returns two flags with the acknowledge. The zero flag is high when any listening device holds 0 at the current bit. The one flag is high when any listening device holds 1. Above the block is a start strobe, the discovered identity with a one-cycle valid, a done level and a sticky error flag.

Top module: `bus_search_master`

## Requirements
- R1: After reset, `done`, `err`, `id_valid` and `bus_req` are all low.
- R2: Every pass issues the operations in this order: a bus reset (op 0), then the search command (op 1), then `ID_W` pairs of response slot (op 2) and decision (op 3). Bit positions run from 0 upward.
- R3: If only one response flag is set, the decision takes that flag's value. If both flags are set, the decision takes the current route's bit. The first pass uses the all-zero route, so on a bus holding 0 and any other identity x, 0 is reported first and x second.
- R4: A completed pass presents its identity on `id_out` with `id_valid` high for exactly one cycle. Bit i of the identity is the decision driven at bit position i, so the identity is assembled LSB first and matches a device on the bus.
- R5: A new route (the current route with bit i set) is queued only when both flags were set at bit i and route bits i and above are all zero. Every device is therefore found exactly once, in exactly as many passes as there are devices.
- R6: If neither flag is set at some bit, the pass is aborted without `id_valid`, `err` is set and the next queued route is taken.
- R7: The queue holds `QDEPTH` pending routes. A push into a full queue sets `err` and is dropped, and stored entries are kept.
- R8: `done` goes high once the queue is empty after the last pass and stays high until the next `start`. `start` clears `done` and `err` and begins with a single all-zero route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin discovery (accepted when idle or done) |
| bus_req | output | 1 | Operation request to the bus engine |
| bus_op | output | 2 | 0 reset, 1 search command, 2 response slots, 3 decision |
| bus_bit | output | 1 | Decision bit for op 3 |
| bus_ack | input | 1 | Engine completed the requested operation |
| bus_zero | input | 1 | A device answered holding 0 (valid with ack of op 2) |
| bus_one | input | 1 | A device answered holding 1 (valid with ack of op 2) |
| id_out | output | ID_W | Discovered identity |
| id_valid | output | 1 | One-cycle strobe for id_out |
| done | output | 1 | Discovery finished |
| err | output | 1 | Aborted pass or queue overflow since start |

## Verification
The hardest conditions to reach are a queue overflow and a pass that gets no answer at all. Neither comes from a well-behaved small population. Overflow is forced by placing every 8-bit identity on a modelled bus, which makes the breadth of pending routes exceed the queue. The silent pass is produced by a bus model that detaches all devices once the first identity has been reported, so the stored second route meets an empty bus. A sweep over every pair {0, x} exercises the branch-on-discrepancy path at each bit position.

// File: rtl/bus_search_master.sv
module bus_search_master #(
  parameter int ID_W   = 64,
  parameter int QDEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            bus_req,
  output logic [1:0]      bus_op,
  output logic            bus_bit,
  input  logic            bus_ack,
  input  logic            bus_zero,
  input  logic            bus_one,
  output logic [ID_W-1:0] id_out,
  output logic            id_valid,
  output logic            done,
  output logic            err
);
  localparam int BW = $clog2(ID_W);
  localparam int PW = $clog2(QDEPTH);
  localparam int CW = $clog2(QDEPTH + 1);

  typedef enum logic [2:0] {S_IDLE, S_POP, S_RST, S_CMD, S_SLOT, S_DEC, S_FIN, S_DONE} st_t;
  st_t st;

  logic [ID_W-1:0] q_mem [QDEPTH];
  logic [PW-1:0]   wr_p, rd_p;
  logic [CW-1:0]   q_cnt;
  logic [ID_W-1:0] route, id_acc;
  logic [BW-1:0]   bpos;
  logic            dec;

  logic both, none, fork_ok, last_bit;
  assign both     = bus_zero & bus_one;
  assign none     = ~bus_zero & ~bus_one;
  assign fork_ok  = both && ((route >> bpos) == '0);
  assign last_bit = (bpos == BW'(ID_W - 1));

  assign bus_req  = (st == S_RST) || (st == S_CMD) || (st == S_SLOT) || (st == S_DEC);
  assign bus_op   = (st == S_CMD) ? 2'd1 : (st == S_SLOT) ? 2'd2 : (st == S_DEC) ? 2'd3 : 2'd0;
  assign bus_bit  = dec;
  assign id_out   = id_acc;
  assign id_valid = (st == S_FIN);
  assign done     = (st == S_DONE);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      wr_p   <= '0;
      rd_p   <= '0;
      q_cnt  <= '0;
      route  <= '0;
      id_acc <= '0;
      bpos   <= '0;
      dec    <= 1'b0;
      err    <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (start) begin
          q_mem[0] <= '0;
          wr_p     <= nxt('0);
          rd_p     <= '0;
          q_cnt    <= CW'(1);
          err      <= 1'b0;
          st       <= S_POP;
        end
        S_POP: if (q_cnt == '0) st <= S_DONE;
        else begin
          route <= q_mem[rd_p];
          rd_p  <= nxt(rd_p);
          q_cnt <= q_cnt - 1'b1;
          st    <= S_RST;
        end
        S_RST: if (bus_ack) st <= S_CMD;
        S_CMD: if (bus_ack) begin
          bpos <= '0;
          st   <= S_SLOT;
        end
        S_SLOT: if (bus_ack) begin
          if (none) begin
            err <= 1'b1;
            st  <= S_POP;
          end else begin
            dec <= both ? route[bpos] : bus_one;
            if (fork_ok) begin
              if (q_cnt == CW'(QDEPTH)) err <= 1'b1;
              else begin
                q_mem[wr_p] <= route | (ID_W'(1) << bpos);
                wr_p        <= nxt(wr_p);
                q_cnt       <= q_cnt + 1'b1;
              end
            end
            st <= S_DEC;
          end
        end
        S_DEC: if (bus_ack) begin
          id_acc[bpos] <= dec;
          if (last_bit) st <= S_FIN;
          else begin
            bpos <= bpos + 1'b1;
            st   <= S_SLOT;
          end
        end
        S_FIN: st <= S_POP;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req && !id_valid);
  // R2
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_op));
  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> !id_valid);
  // R6
  silent_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLOT) && bus_ack && none |=> err && !id_valid);
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= CW'(QDEPTH));
  // R3
  follow_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLOT) && bus_ack && (bus_zero ^ bus_one) |=> bus_bit == $past(bus_one));
endmodule

// File: tb/bus_search_master_tb.sv
module bus_search_master_tb;
  localparam int CLK_P = 10;
  localparam int IW = 8;
  localparam int ND = 1 << IW;

  logic clk = 0, rst_n = 0, start = 0;
  logic bus_req, bus_bit, id_valid, done, err;
  logic [1:0] bus_op;
  logic bus_ack = 0, bus_zero = 0, bus_one = 0;
  logic [IW-1:0] id_out;

  bus_search_master #(.ID_W(IW), .QDEPTH(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_req(bus_req), .bus_op(bus_op),
    .bus_bit(bus_bit), .bus_ack(bus_ack), .bus_zero(bus_zero), .bus_one(bus_one),
    .id_out(id_out), .id_valid(id_valid), .done(done), .err(err));

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0;
  logic [ND-1:0] present, active, found;
  int idx, passes, nfound, seq_err, id_err, dup_err;
  int expect_op;
  logic kill_after_first, last_silent;
  logic [IW-1:0] dec_acc, first_id, second_id;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (id_valid) begin
        if (id_out !== dec_acc || !present[id_out]) id_err++;
        if (found[id_out]) dup_err++;
        found[id_out] = 1'b1;
        if (nfound == 0) first_id = id_out;
        if (nfound == 1) second_id = id_out;
        nfound++;
      end
      if (bus_ack) bus_ack = 0;
      else if (bus_req) begin
        case (bus_op)
          2'd0: begin
            if (!(expect_op == 0 || (expect_op == 2 && last_silent))) seq_err++;
            if (kill_after_first && passes >= 1) present = '0;
            passes++;
            expect_op = 1;
          end
          2'd1: begin
            if (expect_op != 1) seq_err++;
            active = present; idx = 0; expect_op = 2;
          end
          2'd2: begin
            if (expect_op != 2) seq_err++;
            bus_zero = 0; bus_one = 0;
            for (int d = 0; d < ND; d++)
              if (active[d]) begin
                if (d[idx]) bus_one = 1; else bus_zero = 1;
              end
            last_silent = !bus_zero && !bus_one;
            expect_op = 3;
          end
          default: begin
            if (expect_op != 3) seq_err++;
            dec_acc[idx] = bus_bit;
            for (int d = 0; d < ND; d++) if (d[idx] != bus_bit) active[d] = 1'b0;
            idx++;
            expect_op = (idx == IW) ? 0 : 2;
          end
        endcase
        bus_ack = 1;
      end
    end
  end

  task automatic run(output int to);
    found = '0; passes = 0; nfound = 0; seq_err = 0; id_err = 0; dup_err = 0;
    expect_op = 0; last_silent = 0; dec_acc = '0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    to = 0;
    for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
    if (!done) to = 1;
  endtask

  int to, ndev;
  initial begin
    present = '0; active = '0; found = '0; kill_after_first = 0;
    repeat (3) @(negedge clk);
    check(!done && !err && !id_valid && !bus_req, "R1 reset outputs", {done, err, id_valid, bus_req}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!done && !bus_req, "R1 idle after reset", {done, bus_req}, 0);

    // R3 R4 R5 R2: sweep pairs {0, x}
    for (int x = 1; x < ND; x++) begin
      present = '0; present[0] = 1; present[x] = 1;
      run(to);
      check(!to, "R8 pair done", to, 0);
      check(nfound == 2 && passes == 2 && dup_err == 0, "R5 pair count", nfound*100+passes, 202);
      check(first_id == 0 && second_id == IW'(x), "R3 pair order", second_id, x);
      check(id_err == 0, "R4 identity bits", id_err, 0);
      check(seq_err == 0, "R2 op order", seq_err, 0);
      check(!err, "R7 pair no err", err, 0);
    end

    // R7 boundary: 9 devices fill queue exactly
    present = '0; present[0] = 1;
    for (int b = 0; b < IW; b++) present[1 << b] = 1;
    run(to);
    check(!to && !err, "R7 full queue no err", err, 0);
    check(nfound == 9 && passes == 9 && dup_err == 0 && id_err == 0, "R5 nine devices", nfound, 9);

    // R5 mixed population
    present = '0; ndev = 0;
    for (int d = 0; d < ND; d += 37) begin present[d] = 1; ndev++; end
    run(to);
    check(!to && !err, "R5 mixed no err", err, 0);
    check(nfound == ndev && passes == ndev && dup_err == 0 && id_err == 0, "R5 mixed count", nfound, ndev);
    check(seq_err == 0, "R2 mixed order", seq_err, 0);

    // R7 overflow: every identity present
    present = '1;
    run(to);
    check(!to && err, "R7 overflow sets err", err, 1);
    check(nfound > 0 && dup_err == 0 && id_err == 0, "R7 overflow ids distinct", dup_err, 0);

    // R6 empty bus
    present = '0;
    run(to);
    check(!to && err && nfound == 0 && passes == 1, "R6 empty bus", nfound*100+passes, 1);

    // R6 devices vanish after first pass
    present = '0; present[0] = 1; present[8'h80] = 1; kill_after_first = 1;
    run(to);
    kill_after_first = 0;
    check(!to && err, "R6 silent pass err", err, 1);
    check(nfound == 1 && passes == 2, "R6 silent pass no id", nfound*100+passes, 102);

    // R8 start clears err and done
    present = '0; present[5] = 1;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(!done && !err, "R8 start clears", {done, err}, 0);
    for (int c = 0; c < 2000 && !done; c++) @(negedge clk);
    check(done && !err, "R8 done after run", {done, err}, 2);
    repeat (5) @(negedge clk);
    check(done && !bus_req, "R8 done holds", done, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule